// File: doc/BRIEF.md
# Two-Dimensional Bucket Allreduce Sequencer

This block sequences one node's part of an allreduce on a logical torus of ROWS by COLS nodes. It does not move or add any data itself. Each round, it tells the surrounding logic which ring to use (row or column), which buffer segment to send, and which segment to receive. It also says whether the received data is added into the local buffer or overwrites it. Ring hardware reports the end of each round on `roundAck`, and the sequencer then advances.

The local buffer is split into COLS segments, and each segment is split into ROWS sub-segments. The work runs in three stages:

- A reduce-scatter along the row ring. Afterwards the node holds the row-wide sum of segment (rowRank+1) mod COLS.
- An allreduce of only that segment along the column ring. This is a reduce-scatter over sub-segments followed by an allgather over sub-segments.
- An allgather along the row ring, which spreads the finished segments to every node in the row.

A dimension of size one has no partner, so its stages are skipped.

Top module: `bucket_allreduce_seq`

## Requirements
- R1: While reset is held, and afterwards until `start`, `busy`, `done`, `phaseEnter`, `rowActive` and `colActive` are all 0 and `phaseId` is 0.
- R2: A `start` seen in idle begins the row reduce-scatter on the next cycle. `phaseId` is 1, only `rowActive` is high, and `accumulate` and `wholeSeg` are both 1.
- R3: In row reduce-scatter round t (t from 0 to COLS-2), `sendSeg` is (rowRank-t) mod COLS and `recvSeg` is (rowRank-t-1) mod COLS. A round ends only on a cycle with `roundAck` high, and the outputs hold their values without it.
- R4: In the column stage, `phaseId` is 2 and only `colActive` is high. `wholeSeg` is 0, and `sendSeg` and `recvSeg` both equal (rowRank+1) mod COLS. The first ROWS-1 rounds add (`accumulate` 1): in round t, `sendSub` is (colRank-t) mod ROWS and `recvSub` is (colRank-t-1) mod ROWS.
- R5: The next ROWS-1 column rounds overwrite (`accumulate` 0): in round t, `sendSub` is (colRank+1-t) mod ROWS and `recvSub` is (colRank-t) mod ROWS.
- R6: The row allgather has COLS-1 rounds, with `phaseId` 3, only `rowActive` high, `accumulate` 0 and `wholeSeg` 1. In round t, `sendSeg` is (rowRank+1-t) mod COLS and `recvSeg` is (rowRank-t) mod COLS.
- R7: `done` is high for exactly one cycle, the cycle after the final round's `roundAck`. `busy` is 0 in that same cycle.
- R8: A `start` asserted while busy has no effect on the schedule.
- R9: When COLS is 1, both row stages are skipped: `start` leads straight to the column stage, and the run ends after 2(ROWS-1) rounds.
- R10: When ROWS is 1, the column stage is skipped and the run takes 2(COLS-1) row rounds.
- R11: `phaseEnter` is high in the first round of each stage, where `phaseId` takes a new value. It stays low at the change from adding to overwriting inside the column stage, and low in all other rounds.
- R12: `roundAck` while idle has no effect, and the next run starts from round 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an allreduce (sampled in idle only) |
| roundAck | input | 1 | Current ring round has completed |
| rowRank | input | CW | Node position in its row ring |
| colRank | input | RW | Node position in its column ring |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| phaseEnter | output | 1 | First round of a new stage |
| phaseId | output | 2 | 0 idle, 1 row reduce-scatter, 2 column allreduce, 3 row allgather |
| rowActive | output | 1 | Row ring carries this round |
| colActive | output | 1 | Column ring carries this round |
| accumulate | output | 1 | 1: add received data, 0: overwrite |
| wholeSeg | output | 1 | Transfer covers a whole segment (all sub-segments) |
| sendSeg | output | CW | Segment to send |
| recvSeg | output | CW | Segment to receive into |
| sendSub | output | RW | Sub-segment to send (column stage) |
| recvSub | output | RW | Sub-segment to receive into (column stage) |

## Verification
The bench steers toward the corner cases of this block:

- **Modular wrap.** Ranks at zero and at the top of each ring force the indices to wrap. A design with an off-by-one in the rotation would pair the wrong segments and leave the sum incomplete.
- **Column stage boundaries.** The column stage must work only on segment (rowRank+1) mod COLS, and its allgather must start one sub-segment ahead of its reduce-scatter. Getting either wrong would overwrite unreduced data.
- **Stray and withheld inputs.** The bench holds rounds with no acknowledge, sends acknowledges while idle, and asserts `start` in the middle of a run. These catch a design that advances on its own or restarts halfway.
- **Degenerate dimensions.** Two instances with a dimension of size one check that the empty stages are skipped, instead of costing a stray round or hanging on a zero-length round count.

// File: rtl/bucket_seq_pkg.sv
package bucket_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ROW_RS = 3'd1,
    PH_COL_RS = 3'd2,
    PH_COL_AG = 3'd3,
    PH_ROW_AG = 3'd4
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;  // enter stage tgt: reset round count, seed pointer
    logic   step;  // advance one round within stage tgt
    phase_e tgt;
  } seq_ctl_t;

endpackage

// File: rtl/bucket_seq_ctrl.sv
module bucket_seq_ctrl
  import bucket_seq_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     roundAck,
  input  logic     lastRound,
  output phase_e   curPh,
  output seq_ctl_t ctl,
  output logic     busy,
  output logic     done,
  output logic     phaseEnter
);

  localparam phase_e FIRST_PH = (COLS > 1) ? PH_ROW_RS :
                                ((ROWS > 1) ? PH_COL_RS : PH_IDLE);
  localparam phase_e AFTER_ROW_RS = (ROWS > 1) ? PH_COL_RS : PH_ROW_AG;
  localparam phase_e AFTER_COL_AG = (COLS > 1) ? PH_ROW_AG : PH_IDLE;

  phase_e nxtPh;
  logic   finishing;

  function automatic phase_e followOf(input phase_e p);
    case (p)
      PH_ROW_RS: return AFTER_ROW_RS;
      PH_COL_RS: return PH_COL_AG;
      PH_COL_AG: return AFTER_COL_AG;
      default:   return PH_IDLE;
    endcase
  endfunction

  always_comb begin
    nxtPh     = curPh;
    finishing = 1'b0;
    ctl.load  = 1'b0;
    ctl.step  = 1'b0;
    ctl.tgt   = curPh;
    if (curPh == PH_IDLE) begin
      if (start) begin
        nxtPh     = FIRST_PH;
        ctl.tgt   = FIRST_PH;
        ctl.load  = (FIRST_PH != PH_IDLE);
        finishing = (FIRST_PH == PH_IDLE);
      end
    end else if (roundAck) begin
      if (lastRound) begin
        nxtPh     = followOf(curPh);
        ctl.tgt   = nxtPh;
        ctl.load  = (nxtPh != PH_IDLE);
        finishing = (nxtPh == PH_IDLE);
      end else begin
        ctl.step = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPh      <= PH_IDLE;
      done       <= 1'b0;
      phaseEnter <= 1'b0;
    end else begin
      curPh      <= nxtPh;
      done       <= finishing;
      phaseEnter <= ctl.load && (ctl.tgt != PH_COL_AG);
    end
  end

  assign busy = (curPh != PH_IDLE);

  // R12: idle stays idle unless start is seen
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy && !done);

  // R7: the completion pulse never overlaps a running sequence
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: completion is caused by a final acknowledge (or empty start)
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(roundAck) || $past(start)));

endmodule

// File: rtl/bucket_seq_path.sv
module bucket_seq_path
  import bucket_seq_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_ctl_t      ctl,
  input  phase_e        curPh,
  input  logic [CW-1:0] rowRank,
  input  logic [RW-1:0] colRank,
  output logic          lastRound,
  output logic [1:0]    phaseId,
  output logic          rowActive,
  output logic          colActive,
  output logic          accumulate,
  output logic          wholeSeg,
  output logic [CW-1:0] sendSeg,
  output logic [CW-1:0] recvSeg,
  output logic [RW-1:0] sendSub,
  output logic [RW-1:0] recvSub
);

  localparam int PW   = (CW > RW) ? CW : RW;
  localparam int MAXD = (ROWS > COLS) ? ROWS : COLS;
  localparam int NW   = $clog2(MAXD + 1);

  logic [PW-1:0] ptr, prevPtr, initPtr, rowExt, colExt, ownSeg;
  logic [NW-1:0] roundCnt;
  logic          rowPhase, colPhase;
  int            dimN, tgtN;

  function automatic logic [PW-1:0] stepDown(input logic [PW-1:0] v, input int n);
    return (v == '0) ? PW'(n - 1) : v - PW'(1);
  endfunction

  function automatic logic [PW-1:0] stepUp(input logic [PW-1:0] v, input int n);
    return (int'(v) == n - 1) ? '0 : v + PW'(1);
  endfunction

  assign rowExt = PW'(rowRank);
  assign colExt = PW'(colRank);
  assign ownSeg = stepUp(rowExt, COLS);

  assign rowPhase = (curPh == PH_ROW_RS) || (curPh == PH_ROW_AG);
  assign colPhase = (curPh == PH_COL_RS) || (curPh == PH_COL_AG);

  always_comb begin
    dimN = rowPhase ? COLS : ROWS;
    tgtN = ((ctl.tgt == PH_ROW_RS) || (ctl.tgt == PH_ROW_AG)) ? COLS : ROWS;
    case (ctl.tgt)
      PH_ROW_RS: initPtr = rowExt;
      PH_COL_RS: initPtr = colExt;
      PH_COL_AG: initPtr = stepUp(colExt, ROWS);
      PH_ROW_AG: initPtr = stepUp(rowExt, COLS);
      default:   initPtr = '0;
    endcase
  end

  assign prevPtr   = stepDown(ptr, dimN);
  assign lastRound = (roundCnt == NW'(dimN - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      roundCnt <= '0;
    end else if (ctl.load) begin
      ptr      <= initPtr;
      roundCnt <= '0;
    end else if (ctl.step) begin
      ptr      <= stepDown(ptr, tgtN);
      roundCnt <= roundCnt + NW'(1);
    end
  end

  always_comb begin
    case (curPh)
      PH_ROW_RS:            phaseId = 2'd1;
      PH_COL_RS, PH_COL_AG: phaseId = 2'd2;
      PH_ROW_AG:            phaseId = 2'd3;
      default:              phaseId = 2'd0;
    endcase
  end

  assign rowActive  = rowPhase;
  assign colActive  = colPhase;
  assign accumulate = (curPh == PH_ROW_RS) || (curPh == PH_COL_RS);
  assign wholeSeg   = rowPhase;
  assign sendSeg    = rowPhase ? ptr[CW-1:0]     : ownSeg[CW-1:0];
  assign recvSeg    = rowPhase ? prevPtr[CW-1:0] : ownSeg[CW-1:0];
  assign sendSub    = colPhase ? ptr[RW-1:0]     : '0;
  assign recvSub    = colPhase ? prevPtr[RW-1:0] : '0;

  // R3: pointer and round count move only on a control strobe
  assert_hold_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.step) |=> ($stable(ptr) && $stable(roundCnt)));

  // R3: round count never runs past the largest ring
  assert_round_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(roundCnt) < MAXD);

endmodule

// File: rtl/bucket_allreduce_seq.sv
module bucket_allreduce_seq
  import bucket_seq_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          roundAck,
  input  logic [CW-1:0] rowRank,
  input  logic [RW-1:0] colRank,
  output logic          busy,
  output logic          done,
  output logic          phaseEnter,
  output logic [1:0]    phaseId,
  output logic          rowActive,
  output logic          colActive,
  output logic          accumulate,
  output logic          wholeSeg,
  output logic [CW-1:0] sendSeg,
  output logic [CW-1:0] recvSeg,
  output logic [RW-1:0] sendSub,
  output logic [RW-1:0] recvSub
);

  seq_ctl_t ctl;
  phase_e   curPh;
  logic     lastRound;

  bucket_seq_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .roundAck   (roundAck),
    .lastRound  (lastRound),
    .curPh      (curPh),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .phaseEnter (phaseEnter)
  );

  bucket_seq_path #(.ROWS(ROWS), .COLS(COLS)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .curPh      (curPh),
    .rowRank    (rowRank),
    .colRank    (colRank),
    .lastRound  (lastRound),
    .phaseId    (phaseId),
    .rowActive  (rowActive),
    .colActive  (colActive),
    .accumulate (accumulate),
    .wholeSeg   (wholeSeg),
    .sendSeg    (sendSeg),
    .recvSeg    (recvSeg),
    .sendSub    (sendSub),
    .recvSub    (recvSub)
  );

  // R2: only one ring is ever driven in a round
  assert_one_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rowActive && colActive));

  // R11: a stage entry is always inside a running sequence
  assert_enter_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    phaseEnter |-> busy);

endmodule

// File: tb/bucket_allreduce_seq_tb.sv
module bucket_allreduce_seq_tb;

  localparam int R = 3;
  localparam int C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int nChk = 0;
  int nBad = 0;

  // main instance 3 x 4
  logic       start = 1'b0, roundAck = 1'b0;
  logic [1:0] rowRank = '0, colRank = '0;
  logic       busy, done, phaseEnter, rowActive, colActive, accumulate, wholeSeg;
  logic [1:0] phaseId, sendSeg, recvSeg, sendSub, recvSub;

  bucket_allreduce_seq #(.ROWS(R), .COLS(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .roundAck(roundAck),
    .rowRank(rowRank), .colRank(colRank), .busy(busy), .done(done),
    .phaseEnter(phaseEnter), .phaseId(phaseId), .rowActive(rowActive),
    .colActive(colActive), .accumulate(accumulate), .wholeSeg(wholeSeg),
    .sendSeg(sendSeg), .recvSeg(recvSeg), .sendSub(sendSub), .recvSub(recvSub));

  // ROWS = 1 instance (column stage skipped)
  logic       nrStart = 1'b0, nrAck = 1'b0;
  logic [1:0] nrRowRank = 2'd2;
  logic       nrColRank = 1'b0;
  logic       nrBusy, nrDone, nrEnter, nrRowA, nrColA, nrAcc, nrWhole;
  logic [1:0] nrPh, nrSSeg, nrRSeg;
  logic       nrSSub, nrRSub;

  bucket_allreduce_seq #(.ROWS(1), .COLS(3)) u_noRow (
    .clk(clk), .rst_n(rst_n), .start(nrStart), .roundAck(nrAck),
    .rowRank(nrRowRank), .colRank(nrColRank), .busy(nrBusy), .done(nrDone),
    .phaseEnter(nrEnter), .phaseId(nrPh), .rowActive(nrRowA),
    .colActive(nrColA), .accumulate(nrAcc), .wholeSeg(nrWhole),
    .sendSeg(nrSSeg), .recvSeg(nrRSeg), .sendSub(nrSSub), .recvSub(nrRSub));

  // COLS = 1 instance (row stages skipped)
  logic       ncStart = 1'b0, ncAck = 1'b0;
  logic       ncRowRank = 1'b0;
  logic [1:0] ncColRank = 2'd1;
  logic       ncBusy, ncDone, ncEnter, ncRowA, ncColA, ncAcc, ncWhole;
  logic [1:0] ncPh, ncSSub, ncRSub;
  logic       ncSSeg, ncRSeg;

  bucket_allreduce_seq #(.ROWS(3), .COLS(1)) u_noCol (
    .clk(clk), .rst_n(rst_n), .start(ncStart), .roundAck(ncAck),
    .rowRank(ncRowRank), .colRank(ncColRank), .busy(ncBusy), .done(ncDone),
    .phaseEnter(ncEnter), .phaseId(ncPh), .rowActive(ncRowA),
    .colActive(ncColA), .accumulate(ncAcc), .wholeSeg(ncWhole),
    .sendSeg(ncSSeg), .recvSeg(ncRSeg), .sendSub(ncSSub), .recvSub(ncRSub));

  function automatic int md(input int a, input int n);
    return ((a % n) + n) % n;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // checks one round of the main instance, then acknowledges it
  task automatic doRound(input string req, input int ph, input int acc, input int whole,
                         input int sSeg, input int rSeg, input int subOn,
                         input int sSub, input int rSub, input int enter);
    check(req, "phaseId", int'(phaseId), ph);
    check(req, "rowActive", int'(rowActive), (ph == 1 || ph == 3) ? 1 : 0);
    check(req, "colActive", int'(colActive), (ph == 2) ? 1 : 0);
    check(req, "accumulate", int'(accumulate), acc);
    check(req, "wholeSeg", int'(wholeSeg), whole);
    check(req, "sendSeg", int'(sendSeg), sSeg);
    check(req, "recvSeg", int'(recvSeg), rSeg);
    if (subOn != 0) begin
      check(req, "sendSub", int'(sendSub), sSub);
      check(req, "recvSub", int'(recvSub), rSub);
    end
    check("R11", "phaseEnter", int'(phaseEnter), enter);
    check(req, "busy", int'(busy), 1);
    roundAck = 1'b1;
    @(negedge clk);
    roundAck = 1'b0;
  endtask

  task automatic runMain(input int r, input int c, input bit holdTest, input bit busyStart);
    @(negedge clk);
    rowRank = 2'(r);
    colRank = 2'(c);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // row reduce-scatter
    for (int t = 0; t < C - 1; t++) begin
      if (holdTest && t == 1) begin
        repeat (3) @(negedge clk);
        check("R3", "hold sendSeg", int'(sendSeg), md(r - t, C));
      end
      doRound((t == 0) ? "R2" : "R3", 1, 1, 1, md(r - t, C), md(r - t - 1, C),
              0, 0, 0, (t == 0) ? 1 : 0);
    end
    // column reduce-scatter half
    for (int t = 0; t < R - 1; t++) begin
      if (busyStart && t == 0) start = 1'b1;
      doRound("R4", 2, 1, 0, md(r + 1, C), md(r + 1, C),
              1, md(c - t, R), md(c - t - 1, R), (t == 0) ? 1 : 0);
      start = 1'b0;
    end
    // column allgather half
    for (int t = 0; t < R - 1; t++) begin
      doRound("R5", 2, 0, 0, md(r + 1, C), md(r + 1, C),
              1, md(c + 1 - t, R), md(c - t, R), 0);
    end
    // row allgather
    for (int t = 0; t < C - 1; t++) begin
      doRound(busyStart ? "R8" : "R6", 3, 0, 1, md(r + 1 - t, C), md(r - t, C),
              0, 0, 0, (t == 0) ? 1 : 0);
    end
    check("R7", "done after final ack", int'(done), 1);
    check("R7", "busy with done", int'(busy), 0);
    @(negedge clk);
    check("R7", "done single cycle", int'(done), 0);
    check("R7", "phaseId back to idle", int'(phaseId), 0);
  endtask

  task automatic testReset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "phaseEnter", int'(phaseEnter), 0);
    check("R1", "phaseId", int'(phaseId), 0);
    check("R1", "rowActive", int'(rowActive), 0);
    check("R1", "colActive", int'(colActive), 0);
  endtask

  task automatic testIdleAck();
    roundAck = 1'b1;
    repeat (2) @(negedge clk);
    roundAck = 1'b0;
    check("R12", "phaseId after idle ack", int'(phaseId), 0);
    check("R12", "busy after idle ack", int'(busy), 0);
    check("R12", "done after idle ack", int'(done), 0);
    runMain(2, 1, 1'b0, 1'b0);
  endtask

  task automatic testNoRow();
    @(negedge clk);
    nrStart = 1'b1;
    @(negedge clk);
    nrStart = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R10", "phaseId", int'(nrPh), (k < 2) ? 1 : 3);
      check("R10", "colActive", int'(nrColA), 0);
      check("R10", "rowActive", int'(nrRowA), 1);
      check("R10", "phaseEnter", int'(nrEnter), (k == 0 || k == 2) ? 1 : 0);
      if (k == 2) check("R10", "allgather sendSeg", int'(nrSSeg), md(2 + 1, 3));
      nrAck = 1'b1;
      @(negedge clk);
      nrAck = 1'b0;
    end
    check("R10", "done", int'(nrDone), 1);
    check("R10", "busy", int'(nrBusy), 0);
  endtask

  task automatic testNoCol();
    @(negedge clk);
    ncStart = 1'b1;
    @(negedge clk);
    ncStart = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R9", "phaseId", int'(ncPh), 2);
      check("R9", "rowActive", int'(ncRowA), 0);
      check("R9", "colActive", int'(ncColA), 1);
      check("R9", "accumulate", int'(ncAcc), (k < 2) ? 1 : 0);
      check("R9", "phaseEnter", int'(ncEnter), (k == 0) ? 1 : 0);
      if (k == 0) check("R9", "sendSub", int'(ncSSub), 1);
      if (k == 2) check("R9", "sendSub", int'(ncSSub), md(1 + 1, 3));
      ncAck = 1'b1;
      @(negedge clk);
      ncAck = 1'b0;
    end
    check("R9", "done", int'(ncDone), 1);
    check("R9", "busy", int'(ncBusy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runMain(0, 0, 1'b0, 1'b0);
    runMain(3, 2, 1'b1, 1'b0);
    runMain(1, 1, 1'b0, 1'b1);
    testIdleAck();
    testNoRow();
    testNoCol();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule